// File: doc/BRIEF.md
# Nine-Bit Flagged SPI Register Writer

This block sends register writes to a display controller over a write-only serial link whose words are nine bits long. The ninth bit of each word, which goes out first, tells the receiver whether the other eight bits are a register address or a byte of data. A host hands over one request with an address, a payload length of zero, one or two bytes, and the payload. The block then sends that request as a single frame under one chip-select assertion: the address word comes first and the data words follow. When chip select has been released the block pulses `done`.

The serial clock is made inside the block by dividing the system clock. Each half of an SCLK period lasts `HALF_CYC` system cycles, so the smallest divide ratio is 2. The link runs in SPI mode 3. SCLK rests high, MOSI changes after a falling edge, and the receiver samples MOSI on the rising edge. Chip select is active low. It falls one half period before the first SCLK edge and rises one half period after the last rising edge. The block takes a new request only while `req_ready` is high, which is only when it is idle.

Top module: `spi9_reg_writer`

## Requirements
- R1: After a synchronous reset the block is idle: `spi_csn_n`=1, `spi_sclk`=1, `req_ready`=1, `done`=0.
- R2: Each word is 9 bits and is sent MSB first. Bit 8 is the flag (0 for the address word, 1 for a data word) and bits 7:0 carry the byte.
- R3: A frame carries `req_len`+1 words: 9, 18 or 27 SCLK rising edges for a length of 0, 1 or 2. A length of 3 is sent as 2.
- R4: The address word is always first. With length 1 the data word carries `req_data[7:0]`. With length 2 the first data word carries `req_data[15:8]` and the second carries `req_data[7:0]`.
- R5: SCLK is high whenever chip select is released. While chip select is low, MOSI never changes during an SCLK high phase.
- R6: `spi_csn_n` stays low for the whole frame, with no release between words.
- R7: Chip select falls exactly `HALF_CYC` system cycles before the first SCLK falling edge. It rises exactly `HALF_CYC` cycles after the last SCLK rising edge.
- R8: `req_ready` is low from the cycle after acceptance until the frame completes. A `req_valid` presented while `req_ready` is low is ignored and starts no frame.
- R9: `done` is high for exactly one cycle, in the cycle after chip select rises.
- R10: Inside a frame, each SCLK level lasts exactly `HALF_CYC` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | High while idle and able to accept |
| req_addr | input | 8 | Register address for the command word |
| req_len | input | LEN_W (2) | Payload byte count 0..2 (3 is treated as 2) |
| req_data | input | 8*MAX_BYTES (16) | Payload bytes, high byte sent first |
| spi_csn_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| done | output | 1 | One-cycle pulse after chip select is released |

## Verification
The hardest situation to reach from the ports is a request that arrives while a frame is already in flight. The bench covers it by raising `req_valid` with random fields for several cycles in the middle of many frames. It then checks three things: the frame on the wire still matches the original request, no extra frame appears, and `req_ready` stays low the whole time. The edges of the length field get directed cases: the out-of-range value 3, all-ones and all-zeros bytes, and requests issued back to back at the same cycle `done` appears. Random addresses, lengths and payloads fill in the rest.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = BYTE_W + 1;
  localparam logic FLAG_CMD  = 1'b0;
  localparam logic FLAG_DATA = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_FIN
  } wr_state_t;
endpackage

// File: rtl/spi9_clk_div.sv
module spi9_clk_div #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/spi9_frame_pack.sv
module spi9_frame_pack
  import spi9_pkg::*;
#(
  parameter int MAX_BYTES = 2,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1),
  parameter int FRAME_W   = WORD_W * (MAX_BYTES + 1),
  parameter int CNT_W     = $clog2(FRAME_W + 1)
) (
  input  logic [BYTE_W-1:0]           addr,
  input  logic [LEN_W-1:0]            len,
  input  logic [BYTE_W*MAX_BYTES-1:0] data,
  output logic [FRAME_W-1:0]          frame,
  output logic [CNT_W-1:0]            nbits
);
  int unsigned n_eff;

  always_comb begin
    if (int'(len) > MAX_BYTES) n_eff = MAX_BYTES;
    else                       n_eff = int'(len);
  end

  // word slot 0 is the command; slots 1..MAX_BYTES carry data, left aligned
  logic [WORD_W-1:0] slot [MAX_BYTES+1];
  assign slot[0] = {FLAG_CMD, addr};

  for (genvar gi = 0; gi < MAX_BYTES; gi++) begin : g_slot
    logic [BYTE_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int b = 0; b < MAX_BYTES; b++) begin
        if (gi < int'(n_eff) && b == int'(n_eff) - 1 - gi) begin
          pick = data[b*BYTE_W +: BYTE_W];
        end
      end
    end
    assign slot[gi+1] = (gi < int'(n_eff)) ? {FLAG_DATA, pick} : '0;
  end

  for (genvar gs = 0; gs <= MAX_BYTES; gs++) begin : g_place
    assign frame[FRAME_W-1-gs*WORD_W -: WORD_W] = slot[gs];
  end

  assign nbits = CNT_W'(WORD_W * (n_eff + 1));
endmodule

// File: rtl/spi9_shift_out.sv
module spi9_shift_out #(
  parameter int FRAME_W = 27,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_bits,
  input  logic [CNT_W-1:0]   load_cnt,
  input  logic               shift,
  output logic               bit_out,
  output logic               last_bit
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      sh_q  <= load_bits;
      rem_q <= load_cnt;
    end else if (shift) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      rem_q <= rem_q - 1'b1;
    end
  end

  assign bit_out  = sh_q[FRAME_W-1];
  assign last_bit = (rem_q == CNT_W'(1));
endmodule

// File: rtl/spi9_reg_writer.sv
module spi9_reg_writer
  import spi9_pkg::*;
#(
  parameter int HALF_CYC  = 2,
  parameter int MAX_BYTES = 2,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [BYTE_W-1:0]           req_addr,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [BYTE_W*MAX_BYTES-1:0] req_data,
  output logic                        spi_csn_n,
  output logic                        spi_sclk,
  output logic                        spi_mosi,
  output logic                        done
);
  localparam int FRAME_W = WORD_W * (MAX_BYTES + 1);
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  wr_state_t state_q;
  logic csn_q, sclk_q, done_q, ready_q;
  logic tick, accept, do_shift, last_bit;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign accept   = req_valid && ready_q;
  assign do_shift = (state_q == ST_SHIFT) && tick && sclk_q;

  spi9_clk_div #(.HALF_CYC(HALF_CYC)) div_i (
    .clk  (clk),
    .rst  (rst),
    .en   (state_q inside {ST_LEAD, ST_SHIFT, ST_TAIL}),
    .tick (tick)
  );

  spi9_frame_pack #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W),
                    .FRAME_W(FRAME_W), .CNT_W(CNT_W)) pack_i (
    .addr  (req_addr),
    .len   (req_len),
    .data  (req_data),
    .frame (frame),
    .nbits (nbits)
  );

  spi9_shift_out #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shf_i (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_bits (frame),
    .load_cnt  (nbits),
    .shift     (do_shift),
    .bit_out   (spi_mosi),
    .last_bit  (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      csn_q   <= 1'b1;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            csn_q   <= 1'b0;
            ready_q <= 1'b0;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            sclk_q  <= 1'b0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              if (last_bit) state_q <= ST_TAIL;
            end else begin
              sclk_q <= 1'b0;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            csn_q   <= 1'b1;
            state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          ready_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign spi_csn_n = csn_q;
  assign spi_sclk  = sclk_q;
  assign done      = done_q;
endmodule

// File: rtl/spi9_reg_writer_chk.sv
module spi9_reg_writer_chk #(
  parameter int HALF_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic spi_csn_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic done
);
  localparam int SW = $clog2(HALF_CYC + 2) + 1;
  logic prev_sclk, prev_csn;
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b1;
      prev_csn  <= 1'b1;
      since     <= '0;
    end else begin
      prev_sclk <= spi_sclk;
      prev_csn  <= spi_csn_n;
      if (spi_csn_n)               since <= '0;
      else if (spi_sclk != prev_sclk) since <= SW'(1);
      else                         since <= since + 1'b1;
    end
  end

  // R5: clock rests high outside a frame
  a_r5_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    spi_csn_n |-> spi_sclk);

  // R5: data held across a high phase
  a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (!spi_csn_n && !prev_csn && spi_sclk && prev_sclk) |-> $stable(spi_mosi));

  // R8: never ready while a frame is on the wire
  a_r8_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    !spi_csn_n |-> !req_ready);

  // R9: done is a single pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done follows chip select release
  a_r9_done_after_cs: assert property (@(posedge clk) disable iff (rst)
    done |-> (spi_csn_n && !prev_csn == 1'b0 && $past(spi_csn_n) && !$past(spi_csn_n, 2)));

  // R7 and R10: every level inside a frame lasts HALF_CYC cycles
  a_r10_half_period: assert property (@(posedge clk) disable iff (rst)
    (!prev_csn && (spi_sclk != prev_sclk || spi_csn_n)) |-> (since == SW'(HALF_CYC)));
endmodule

bind spi9_reg_writer spi9_reg_writer_chk #(.HALF_CYC(HALF_CYC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .spi_csn_n (spi_csn_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .done      (done)
);

// File: tb/spi9_reg_writer_tb_top.sv
`timescale 1ns/1ps
module spi9_reg_writer_tb_top;
  localparam int HALF = 3;
  localparam int FW   = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_len  = '0;
  logic [15:0] req_data = '0;
  logic req_ready, spi_csn_n, spi_sclk, spi_mosi, done;

  always #2.5 clk = ~clk;

  spi9_reg_writer #(.HALF_CYC(HALF), .MAX_BYTES(2)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .spi_csn_n(spi_csn_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .done(done)
  );

  int checks = 0, fails = 0, n_sent = 0, n_frames = 0;
  bit finished = 0;
  logic [FW-1:0] exp_bits;
  int exp_n;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int eff_len(input logic [1:0] l);
    return (l == 2'd3) ? 2 : int'(l);
  endfunction

  function automatic logic [FW-1:0] build(input logic [7:0] a, input logic [1:0] l,
                                          input logic [15:0] d);
    case (eff_len(l))
      0: return FW'({1'b0, a});
      1: return FW'({1'b0, a, 1'b1, d[7:0]});
      default: return {1'b0, a, 1'b1, d[15:8], 1'b1, d[7:0]};
    endcase
  endfunction

  // monitor state
  logic pcsn = 1, psclk = 1, pmosi = 0, pdone = 0;
  longint cyc = 0, t_csfall = 0, t_edge = 0, t_rise = 0, t_csrise = -10;
  logic [FW-1:0] cap;
  int nb = 0;
  bit first_fall, bad_r5, bad_r6, bad_r8, bad_r10;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (spi_csn_n && !spi_sclk) bad_r5 = 1;
      if (pcsn && !spi_csn_n) begin
        n_frames++; cap = '0; nb = 0; first_fall = 0; t_csfall = cyc; t_edge = cyc;
        bad_r5 = 0; bad_r8 = 0; bad_r10 = 0;
      end
      if (!spi_csn_n) begin
        if (req_ready) bad_r8 = 1;
        if (psclk && spi_sclk && !pcsn && spi_mosi != pmosi) bad_r5 = 1;
        if (spi_sclk != psclk) begin
          if (cyc - t_edge != HALF) bad_r10 = 1;
          t_edge = cyc;
        end
        if (psclk && !spi_sclk && !first_fall) begin
          first_fall = 1;
          chk(cyc - t_csfall == HALF, "R7 lead", cyc - t_csfall, HALF);
        end
        if (!psclk && spi_sclk) begin
          cap = {cap[FW-2:0], spi_mosi}; nb++; t_rise = cyc;
        end
      end
      if (!pcsn && spi_csn_n) begin
        t_csrise = cyc;
        chk(cyc - t_rise == HALF, "R7 tail", cyc - t_rise, HALF);
        chk(nb == exp_n, "R3 bit count", nb, exp_n);
        chk(cap[nb-1 -: 9] == exp_bits[exp_n-1 -: 9] && cap[nb-1] == 1'b0,
            "R2 command word", cap[nb-1 -: 9], exp_bits[exp_n-1 -: 9]);
        chk(cap == exp_bits, "R4 frame content", cap, exp_bits);
        chk(!bad_r5, "R5 mode 3 timing", bad_r5, 0);
        chk(!bad_r10, "R10 half period", bad_r10, 0);
        chk(!bad_r8, "R8 ready while busy", bad_r8, 0);
      end
      if (!pcsn && !spi_csn_n && !spi_sclk && !psclk && nb == 0 && first_fall == 0) bad_r6 = 1;
      if (done) begin
        chk(cyc == t_csrise + 1 && !pdone, "R9 done timing", cyc - t_csrise, 1);
        chk(!bad_r6, "R6 single frame", bad_r6, 0);
      end
      pcsn = spi_csn_n; psclk = spi_sclk; pmosi = spi_mosi; pdone = done;
    end
  end

  task automatic send(input logic [7:0] a, input logic [1:0] l, input logic [15:0] d,
                      input bit junk, input bit wait_end);
    while (!req_ready) @(negedge clk);
    exp_bits = build(a, l, d);
    exp_n    = 9 * (eff_len(l) + 1);
    req_addr = a; req_len = l; req_data = d; req_valid = 1'b1;
    n_sent++;
    @(negedge clk);
    req_valid = 1'b0;
    if (junk) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1;
      req_addr = 8'($urandom); req_len = 2'($urandom); req_data = 16'($urandom);
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
    end
    if (wait_end) begin
      while (!done) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(spi_csn_n == 1 && spi_sclk == 1 && req_ready == 1 && done == 0,
        "R1 reset state", {spi_csn_n, spi_sclk, req_ready, done}, 4'b1110);
    // directed corners: R3 lengths incl. clamp of 3, R4 byte order
    send(8'h00, 2'd0, 16'hFFFF, 0, 1);
    send(8'hFF, 2'd1, 16'hA55A, 0, 1);
    send(8'hB8, 2'd2, 16'hFFF9, 0, 1);
    send(8'h3C, 2'd3, 16'h1234, 0, 1);
    send(8'hFF, 2'd2, 16'h0000, 1, 1);
    // back to back: next request presented as done rises
    send(8'h11, 2'd0, 16'h0, 0, 1);
    send(8'h29, 2'd1, 16'h00FF, 0, 1);
    send(8'h28, 2'd2, 16'h8002, 0, 1);
    for (int i = 0; i < 50; i++) begin
      send(8'($urandom), 2'($urandom), 16'($urandom), bit'($urandom), 1);
    end
    repeat (20) @(negedge clk);
    chk(n_frames == n_sent, "R8 no extra frame", n_frames, n_sent);
    chk(spi_csn_n == 1 && spi_sclk == 1 && req_ready == 1,
        "R5 idle after run", {spi_csn_n, spi_sclk, req_ready}, 3'b111);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule